// File: doc/BRIEF.md
# Banked GPIO Register Controller

This block is the register side of a general purpose I/O controller organised in banks of 32 pins. A simple single-cycle register port (write strobe, byte address, write data, combinational read data) reaches one control word per pin and a group of registers per bank. Software drives the pin output values through separate set and clear addresses, selects each pin's direction in its control word, and sees the live pin levels in an input status register. Each bank has an interrupt output that stays high while any pending event bit of that bank is unmasked.

Edge detection and debouncing are outside the block. Each pin delivers a one-cycle event pulse, which sets a sticky pending bit that software clears by writing a one. The mask can also be set and cleared through two separate addresses, so no read-modify-write is needed. Pins can be write-protected one at a time. The lock register of a bank accepts a write only when the write directly follows a write of a fixed key to a separate key address. While a pin is locked, its control word and its output set/clear bits cannot be changed.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Per-bank registers sit at byte offset group*0x20 + bank*4. The groups are: 0 output value, 1 input level (reads `pin_in`), 2 output set, 3 output clear, 4 pending events, 5 mask set, 6 mask clear. The lock register is at 0x500 + bank*4. Reads of groups 2 and 3 return 0.
- R2: The control word of global pin p is at 0x100 + 4*p. Bit 0 is the direction, where 1 means input and 0 means output. It reads back as {31'b0, dir}, and `pin_dir_in` shows every pin's direction bit.
- R3: A write to output set forces to 1 each output bit whose data bit is 1. A write to output clear forces each such bit to 0. Output bits whose data bit is 0 keep their value.
- R4: A 1 on `pin_evt` sets that pin's pending bit. Writing 1 to a pending bit clears it. If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R5: Writing 1 to a bit at the mask set address masks that pin. Writing 1 to a bit at the mask clear address unmasks it. Both addresses read the current mask, where 1 means masked.
- R6: `bank_irq[b]` is 1 exactly when bank b has a pending bit whose mask bit is 0.
- R7: A lock register write takes effect only if the write immediately before it was the value 0x00A5A501 to offset 0x520. The next write of any kind, to any address, consumes this arming.
- R8: While a pin's lock bit is 1, writes to its control word and to its output set and clear bits are ignored. A lock value of all ones locks the whole bank, and all zeros unlocks it. Pending and mask writes are not affected by locks.
- R9: At reset, outputs are 0, every pin is an input, all pins are masked, nothing is pending, every bank is locked and the key is not armed.
- R10: Addresses with bits [1:0] not zero, banks at or above NUM_BANKS, pins at or above the pin count, and unused offsets ignore writes and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | 32*NUM_BANKS | Pin levels from the pads |
| pin_evt | input | 32*NUM_BANKS | One-cycle event pulses per pin |
| pin_out | output | 32*NUM_BANKS | Output values |
| pin_dir_in | output | 32*NUM_BANKS | Direction per pin, 1 = input |
| bank_irq | output | NUM_BANKS | Interrupt per bank |

## Verification
The hardest state to reach is an armed key followed by something other than a lock write, and a lock write that only partly protects a bank. Random stimulus seldom produces a key write followed directly by a lock write. So the random mix writes the exact key value often and draws lock and stray addresses often. The directed part builds these sequences explicitly: a key, then an unrelated write, then a lock write, and a half-bank lock followed by set writes of all ones. The random mix also places events in the same cycle as write-one-to-clear writes to the same bit.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned PINS_PER_BANK = 32;
  localparam int unsigned CTRL_WORD0    = 64;          // 0x100 >> 2
  localparam logic [6:0]  LOCK_ROW      = 7'h28;       // 0x500 >> 5
  localparam logic [11:0] KEY_ADDR      = 12'h520;
  localparam logic [31:0] KEY_VALUE     = 32'h00A5A501;

  typedef enum logic [2:0] {
    GRP_OUT  = 3'd0,
    GRP_IN   = 3'd1,
    GRP_OSET = 3'd2,
    GRP_OCLR = 3'd3,
    GRP_PEND = 3'd4,
    GRP_MSET = 3'd5,
    GRP_MCLR = 3'd6,
    GRP_NONE = 3'd7
  } grp_e;

  typedef struct packed {
    logic oset;
    logic oclr;
    logic pclr;
    logic mset;
    logic mclr;
    logic lock;
  } bank_wr_t;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  localparam int unsigned NP = NUM_BANKS * PINS_PER_BANK
) (
  input  logic                 wr_i,
  input  logic [11:0]          addr_i,
  input  logic [31:0]          wdata_i,
  output bank_wr_t [NUM_BANKS-1:0] bwr_o,
  output logic [NP-1:0]        ctrl_we_o,
  output logic                 key_hit_o,
  output grp_e                 grp_o,
  output logic [2:0]           bank_o,
  output logic                 low_ok_o,
  output logic                 lock_ok_o,
  output logic                 ctrl_ok_o,
  output logic [9:0]           word_o
);
  logic aligned, bank_ok;

  always_comb begin
    aligned   = (addr_i[1:0] == 2'b00);
    grp_o     = grp_e'(addr_i[7:5]);
    bank_o    = addr_i[4:2];
    word_o    = addr_i[11:2];
    bank_ok   = int'(bank_o) < int'(NUM_BANKS);
    low_ok_o  = aligned && bank_ok && (addr_i[11:8] == 4'h0);
    lock_ok_o = aligned && bank_ok && (addr_i[11:5] == LOCK_ROW);
    ctrl_ok_o = aligned && (int'(word_o) >= int'(CTRL_WORD0))
                && (int'(word_o) < int'(CTRL_WORD0 + NP));
    key_hit_o = wr_i && (addr_i == KEY_ADDR) && (wdata_i == KEY_VALUE);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_dec
    logic sel;
    assign sel = wr_i && (bank_o == 3'(b));
    assign bwr_o[b].oset = sel && low_ok_o && (grp_o == GRP_OSET);
    assign bwr_o[b].oclr = sel && low_ok_o && (grp_o == GRP_OCLR);
    assign bwr_o[b].pclr = sel && low_ok_o && (grp_o == GRP_PEND);
    assign bwr_o[b].mset = sel && low_ok_o && (grp_o == GRP_MSET);
    assign bwr_o[b].mclr = sel && low_ok_o && (grp_o == GRP_MCLR);
    assign bwr_o[b].lock = sel && lock_ok_o;
  end

  for (genvar p = 0; p < NP; p++) begin : g_ctrl_dec
    assign ctrl_we_o[p] = wr_i && ctrl_ok_o && (word_o == 10'(CTRL_WORD0 + p));
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PW = PINS_PER_BANK
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bank_wr_t      bwr_i,
  input  logic [PW-1:0] ctrl_we_i,
  input  logic [31:0]   wdata_i,
  input  logic          arm_i,
  input  logic [PW-1:0] evt_i,
  output logic [PW-1:0] out_o,
  output logic [PW-1:0] dir_o,
  output logic [PW-1:0] pend_o,
  output logic [PW-1:0] mask_o,
  output logic [PW-1:0] lock_o,
  output logic          irq_o
);
  logic [PW-1:0] out_q, dir_q, pend_q, mask_q, lock_q;
  logic [PW-1:0] out_d, dir_d, pend_d, mask_d, lock_d;
  logic [PW-1:0] wbits, free;
  logic          out_en, dir_en, mask_en, lock_en;
  logic          live_q;

  always_comb begin
    wbits   = wdata_i[PW-1:0];
    free    = ~lock_q;
    out_en  = bwr_i.oset || bwr_i.oclr;
    dir_en  = |(ctrl_we_i & free);
    mask_en = bwr_i.mset || bwr_i.mclr;
    lock_en = bwr_i.lock && arm_i;

    out_d = out_q;
    if (bwr_i.oset) out_d = out_d | (wbits & free);
    if (bwr_i.oclr) out_d = out_d & ~(wbits & free);

    for (int i = 0; i < int'(PW); i++)
      dir_d[i] = (ctrl_we_i[i] && free[i]) ? wdata_i[0] : dir_q[i];

    pend_d = (pend_q & ~(bwr_i.pclr ? wbits : '0)) | evt_i;

    mask_d = mask_q;
    if (bwr_i.mset) mask_d = mask_d | wbits;
    if (bwr_i.mclr) mask_d = mask_d & ~wbits;

    lock_d = wbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '1;
      pend_q <= '0;
      mask_q <= '1;
      lock_q <= '1;
      live_q <= 1'b0;
    end else begin
      live_q <= 1'b1;
      if (out_en)  out_q  <= out_d;
      if (dir_en)  dir_q  <= dir_d;
      pend_q <= pend_d;
      if (mask_en) mask_q <= mask_d;
      if (lock_en) lock_q <= lock_d;
    end
  end

  assign out_o  = out_q;
  assign dir_o  = dir_q;
  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign lock_o = lock_q;
  assign irq_o  = |(pend_q & ~mask_q);

  AST_LOCK_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && !$stable(lock_q) |-> $past(bwr_i.lock && arm_i)); // R7
  AST_LOCKED_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (((out_q ^ $past(out_q)) & $past(lock_q)) == '0)); // R8
  AST_LOCKED_DIR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (((dir_q ^ $past(dir_q)) & $past(lock_q)) == '0)); // R8
  AST_EVT_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> ((pend_q & $past(evt_i)) == $past(evt_i))); // R4
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && $past(bwr_i.pclr) |->
      ((pend_q & $past(wbits & ~evt_i)) == '0)); // R4
  AST_IRQ_ON_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && $past(!bwr_i.mset && (|(evt_i & ~mask_q))) |-> irq_o); // R6
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  localparam int unsigned NP = NUM_BANKS * PINS_PER_BANK
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [11:0]          bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NP-1:0]        pin_in,
  input  logic [NP-1:0]        pin_evt,
  output logic [NP-1:0]        pin_out,
  output logic [NP-1:0]        pin_dir_in,
  output logic [NUM_BANKS-1:0] bank_irq
);
  localparam int unsigned PW = PINS_PER_BANK;

  bank_wr_t [NUM_BANKS-1:0] bwr;
  logic [NP-1:0] ctrl_we;
  logic          key_hit, low_ok, lock_ok, ctrl_ok;
  grp_e          grp;
  logic [2:0]    bank_sel;
  logic [9:0]    word;
  logic          arm_q, arm_d;

  logic [PW-1:0] out_b  [NUM_BANKS];
  logic [PW-1:0] pend_b [NUM_BANKS];
  logic [PW-1:0] mask_b [NUM_BANKS];
  logic [PW-1:0] lock_b [NUM_BANKS];

  gpio_addr_dec #(.NUM_BANKS(NUM_BANKS)) u_dec (
    .wr_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .bwr_o(bwr), .ctrl_we_o(ctrl_we), .key_hit_o(key_hit),
    .grp_o(grp), .bank_o(bank_sel), .low_ok_o(low_ok),
    .lock_ok_o(lock_ok), .ctrl_ok_o(ctrl_ok), .word_o(word)
  );

  // key arming: any write replaces it, only a key hit sets it
  always_comb arm_d = bus_wr ? key_hit : arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= 1'b0;
    else        arm_q <= arm_d;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_bank_regs #(.PW(PW)) u_regs (
      .clk(clk), .rst_n(rst_n), .bwr_i(bwr[b]),
      .ctrl_we_i(ctrl_we[b*PW +: PW]), .wdata_i(bus_wdata), .arm_i(arm_q),
      .evt_i(pin_evt[b*PW +: PW]),
      .out_o(out_b[b]), .dir_o(pin_dir_in[b*PW +: PW]),
      .pend_o(pend_b[b]), .mask_o(mask_b[b]), .lock_o(lock_b[b]),
      .irq_o(bank_irq[b])
    );
    assign pin_out[b*PW +: PW] = out_b[b];
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < int'(NUM_BANKS); b++) begin
      if (bank_sel == 3'(b)) begin
        if (low_ok) begin
          case (grp)
            GRP_OUT:            bus_rdata = out_b[b];
            GRP_IN:             bus_rdata = pin_in[b*PW +: PW];
            GRP_PEND:           bus_rdata = pend_b[b];
            GRP_MSET, GRP_MCLR: bus_rdata = mask_b[b];
            default:            bus_rdata = '0;
          endcase
        end
        if (lock_ok) bus_rdata = lock_b[b];
      end
    end
    for (int p = 0; p < int'(NP); p++)
      if (ctrl_ok && (word == 10'(CTRL_WORD0 + p)))
        bus_rdata = {31'b0, pin_dir_in[p]};
  end

  AST_KEY_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    arm_q && bus_wr && !key_hit |=> !arm_q); // R7
  AST_ARM_ONLY_FROM_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_q && !key_hit |=> !arm_q); // R7
endmodule

// File: tb/test_gpio_bank_ctrl.sv
module test_gpio_bank_ctrl;
  localparam int NB = 2;
  localparam int NP = NB * 32;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY = 32'h00A5A501;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_wr;
  logic [11:0]   bus_addr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in, pin_evt, pin_out, pin_dir_in;
  logic [NB-1:0] bank_irq;

  gpio_bank_ctrl #(.NUM_BANKS(NB)) i_gpio_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_evt(pin_evt), .pin_out(pin_out), .pin_dir_in(pin_dir_in),
    .bank_irq(bank_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;

  logic [31:0] m_out [NB], m_pend [NB], m_mask [NB], m_lock [NB];
  logic [NP-1:0] m_dir;
  logic m_arm;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin
      m_out[b] = '0; m_pend[b] = '0; m_mask[b] = '1; m_lock[b] = '1;
    end
    m_dir = '1; m_arm = 0;
  endtask

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    int b, w;
    b = a[4:2];
    w = a[11:2];
    if (a[1:0] != 0) return '0;
    if (a < 12'h100) begin
      if (b >= NB) return '0;
      case (a[7:5])
        3'd0: return m_out[b];
        3'd1: return pin_in[b*32 +: 32];
        3'd4: return m_pend[b];
        3'd5, 3'd6: return m_mask[b];
        default: return '0;
      endcase
    end
    if (w >= 64 && w < 64 + NP) return {31'b0, m_dir[w-64]};
    if (a[11:5] == 7'h28 && b < NB) return m_lock[b];
    return '0;
  endfunction

  task automatic model_step(input logic wr, input logic [11:0] a,
                            input logic [31:0] d, input logic [NP-1:0] ev);
    int b, w;
    logic arm_n;
    b = a[4:2];
    w = a[11:2];
    arm_n = m_arm;
    if (wr) begin
      arm_n = (a == 12'h520) && (d == KEY);
      if (a[1:0] == 0) begin
        if (a < 12'h100 && b < NB) begin
          case (a[7:5])
            3'd2: m_out[b] = m_out[b] | (d & ~m_lock[b]);
            3'd3: m_out[b] = m_out[b] & ~(d & ~m_lock[b]);
            3'd4: m_pend[b] = m_pend[b] & ~d;
            3'd5: m_mask[b] = m_mask[b] | d;
            3'd6: m_mask[b] = m_mask[b] & ~d;
            default: ;
          endcase
        end else if (w >= 64 && w < 64 + NP) begin
          if (!m_lock[(w-64)/32][(w-64)%32]) m_dir[w-64] = d[0];
        end else if (a[11:5] == 7'h28 && b < NB && m_arm) begin
          m_lock[b] = d;
        end
      end
    end
    for (int k = 0; k < NB; k++) m_pend[k] = m_pend[k] | ev[k*32 +: 32];
    m_arm = arm_n;
  endtask

  task automatic step(input logic wr, input logic [11:0] a,
                      input logic [31:0] d, input logic [NP-1:0] ev);
    bus_wr = wr; bus_addr = a; bus_wdata = d; pin_evt = ev;
    @(posedge clk);
    model_step(wr, a, d, ev);
    @(negedge clk);
    bus_wr = 0; pin_evt = '0;
    for (int k = 0; k < NB; k++)
      chk("R6 irq", 64'(bank_irq[k]), 64'(|(m_pend[k] & ~m_mask[k])));
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    step(1'b1, a, d, '0);
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a);
    bus_addr = a; bus_wr = 0;
    #1;
    chk(req, 64'(bus_rdata), 64'(exp_read(a)));
  endtask

  function automatic logic [11:0] rand_addr();
    int s, b;
    s = $urandom % 12;
    b = $urandom % (NB + 1);
    case (s)
      0, 1, 2, 3, 4, 5: return 12'((($urandom % 7) << 5) | (b << 2));
      6, 7: return 12'h100 + 12'(($urandom % (NP + 4)) << 2);
      8: return 12'h500 + 12'(b << 2);
      9: return 12'h520;
      10: return 12'($urandom % 12'h600);
      default: return 12'h500 + 12'(($urandom % NB) << 2);
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [11:0] a;
    logic [31:0] d;
    logic [NP-1:0] ev;
    void'($urandom(32'd1234));
    rst_n = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    pin_in = '0; pin_evt = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R9 reset state
    chk("R9 pin_out", 64'(pin_out), 64'(0));
    chk("R9 pin_dir_in", 64'(pin_dir_in), {64{1'b1}});
    chk("R9 irq", 64'(bank_irq), 64'(0));
    rd_chk("R9 mask", 12'h0A0);
    rd_chk("R9 lock", 12'h504);
    rd_chk("R9 pend", 12'h084);
    rd_chk("R2 ctrl reset", 12'h100 + 12'd20);

    // R8 locked bank ignores set and control
    wr(12'h040, 32'hFFFF_FFFF);
    chk("R8 locked set", 64'(pin_out), 64'(0));
    wr(12'h104, 32'h0);
    rd_chk("R8 locked ctrl", 12'h104);

    // R7 lock write without key, and key consumed by a stray write
    wr(12'h500, 32'h0);
    rd_chk("R7 no key", 12'h500);
    wr(12'h520, KEY);
    wr(12'h0A0, 32'h0);
    wr(12'h500, 32'h0);
    rd_chk("R7 key consumed", 12'h500);
    wr(12'h520, 32'h00A5A500);
    wr(12'h500, 32'h0);
    rd_chk("R7 wrong key", 12'h500);
    wr(12'h520, KEY);
    wr(12'h500, 32'h0);
    rd_chk("R7 key then lock", 12'h500);

    // R2 direction, R3 set/clear
    wr(12'h10C, 32'h0);
    rd_chk("R2 ctrl write", 12'h10C);
    chk("R2 dir pin3", 64'(pin_dir_in[3]), 64'(0));
    wr(12'h040, 32'h0000_00F0);
    chk("R3 set", 64'(pin_out[31:0]), 64'h0000_00F0);
    wr(12'h060, 32'h0000_0030);
    chk("R3 clear", 64'(pin_out[31:0]), 64'h0000_00C0);
    wr(12'h040, 32'h0);
    rd_chk("R3 zero bits", 12'h000);
    rd_chk("R1 set reads 0", 12'h040);

    // R4 R5 R6 events, mask, irq
    step(1'b0, 12'h0, 32'h0, 64'h4);
    rd_chk("R4 pend set", 12'h080);
    chk("R6 masked no irq", 64'(bank_irq[0]), 64'(0));
    wr(12'h0C0, 32'h4);
    rd_chk("R5 unmask", 12'h0A0);
    chk("R6 irq up", 64'(bank_irq[0]), 64'(1));
    wr(12'h0A0, 32'h4);
    rd_chk("R5 mask via clr addr", 12'h0C0);
    chk("R6 irq down", 64'(bank_irq[0]), 64'(0));
    step(1'b1, 12'h080, 32'h4, 64'h4);
    rd_chk("R4 event beats clear", 12'h080);
    wr(12'h080, 32'h4);
    rd_chk("R4 clear", 12'h080);

    // R10 out of range, misaligned
    wr(12'h04C, 32'hFFFF_FFFF);
    rd_chk("R10 bad bank", 12'h04C);
    wr(12'h041, 32'hFFFF_FFFF);
    chk("R10 misaligned", 64'(pin_out), 64'(m_out[1]) << 32 | 64'(m_out[0]));
    rd_chk("R10 bad pin", 12'h100 + 12'((NP + 2) * 4));
    rd_chk("R10 gap", 12'h0E0);

    // R1 input levels
    pin_in = 64'hDEAD_BEEF_1234_5678;
    rd_chk("R1 input bank0", 12'h020);
    rd_chk("R1 input bank1", 12'h024);

    // R8 partial lock
    wr(12'h520, KEY);
    wr(12'h500, 32'h0000_FFFF);
    wr(12'h040, 32'hFFFF_FFFF);
    chk("R8 partial lock", 64'(pin_out[31:0]), 64'hFFFF_00C0);
    wr(12'h080, 32'h0);
    wr(12'h0C0, 32'h1);
    rd_chk("R8 mask unaffected", 12'h0A0);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      a = rand_addr();
      d = ($urandom % 5 == 0) ? KEY : (($urandom % 4 == 0) ? 32'h0 : $urandom);
      if ($urandom % 3 == 0) ev = {$urandom, $urandom} & {$urandom, $urandom};
      else ev = '0;
      pin_in = {$urandom, $urandom};
      step(($urandom % 5) != 0, a, d, ev);
      rd_chk("R1 random read", rand_addr());
      if (n % 50 == 0) begin
        chk("R3 random out", 64'(pin_out), {32'(m_out[1]), 32'(m_out[0])});
        chk("R2 random dir", 64'(pin_dir_in), 64'(m_dir));
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule